// File: doc/BRIEF.md
# Excitation Self-Test Sequencer

This block paces a periodic self-test of the comparator channels in one crate. Once started, it walks a stored excitation waveform: 128 samples per period, three periods per channel, channel after channel up to sixteen. At every sample interval it latches the current table word onto the modulation output and raises a one-cycle bus request. The interval length comes from a clock-count value latched at start, so one design serves both the real 26 ms spacing and a short spacing for simulation.

Three crates start together through a shared open-drain line. Each crate holds the line low while idle and lets go once it has been started. Sampling only begins when the line, passed through a synchronizer, reads high. Only the crate strapped as master drives the high-voltage modulation. An abort input stops the run at once, clears the modulation output and raises a failure flag.

Top module: `exc_sequencer`

## Requirements
- R1: After reset, busy_o, done_o, bus_req_o, hv_en_o and fail_o are 0, mod_o is 0 and rel_pull_o is 1.
- R2: A start_i pulse while idle makes busy_o 1 and rel_pull_o 0 one cycle later. No bus request occurs while rel_i is low. Sampling begins only after rel_i has passed a two-stage synchronizer.
- R3: Within a channel, consecutive bus_req_o pulses are exactly the latched interval apart in cycles, and an interval value of 0 acts as 1. The gap across a channel change is the interval plus one.
- R4: On each bus_req_o pulse, mod_o holds the samp_data_i word that was presented for that sample. Sample addresses run 0 to 127 in ascending order, three times per channel, and channels run upward from 0.
- R5: The number of channels is n_chan_i latched at start, with 0 treated as 1 and values above 16 treated as 16. A run issues exactly channels × 384 bus requests.
- R6: done_o is a single-cycle pulse in the cycle after the final bus request. In the cycle after that, busy_o is 0 and rel_pull_o is 1.
- R7: Changes to interval_i and n_chan_i, and start_i pulses, during a run have no effect on its schedule.
- R8: abort_i makes busy_o 0, mod_o 0 and fail_o 1 in the next cycle, and no further bus requests follow. fail_o clears when the next start is accepted.
- R9: hv_en_o is 1 during sampling only when is_master_i is 1, and it is never 1 while busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request pulse |
| abort_i | input | 1 | Abort the run and flag a failure |
| is_master_i | input | 1 | This crate drives the HV modulation |
| interval_i | input | 24 | Clock cycles per sample interval |
| n_chan_i | input | 5 | Number of channels to test |
| rel_i | input | 1 | Level of the shared release line |
| samp_data_i | input | 32 | Table word at samp_addr_o / chan_o |
| rel_pull_o | output | 1 | Pull the shared line low |
| samp_addr_o | output | 7 | Current sample address |
| chan_o | output | 4 | Current channel |
| mod_o | output | 32 | Latched excitation sample |
| bus_req_o | output | 1 | One-cycle request per sample interval |
| hv_en_o | output | 1 | HV modulation enable |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run complete pulse |
| fail_o | output | 1 | Run was aborted |

## Verification
The bench checks the gap after each channel change. A design that reuses the stale timer count there, or skips the one-cycle channel step, shows a gap different from the interval plus one. It also clamps the channel count at 0 and above 16: an unclamped count either wraps to an endless run or stops early, and the request total comes out wrong. Parameters are changed and start_i is pulsed in the middle of a run, so a design that does not latch its settings shifts the spacing or cuts the run short. Abort is checked for an immediate stop and a zeroed output, and fail_o must clear when the next start is accepted.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_RUN,
    S_NEXT,
    S_DONE
  } seq_state_t;
endpackage

// File: rtl/exc_rel_sync.sv
module exc_rel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= d_i;
        else sync_q[g] <= sync_q[(g > 0) ? g - 1 : 0];
      end
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/exc_interval_timer.sv
module exc_interval_timer #(
  parameter int W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] limit_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == limit_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/exc_pos_counter.sv
module exc_pos_counter #(
  parameter int N_SAMP = 128,
  parameter int N_PER  = 3,
  parameter int N_CH   = 16,
  localparam int SA_W  = $clog2(N_SAMP),
  localparam int PER_W = (N_PER > 1) ? $clog2(N_PER) : 1,
  localparam int CH_W  = $clog2(N_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            step_i,
  input  logic            ch_adv_i,
  output logic [SA_W-1:0] samp_o,
  output logic [CH_W-1:0] chan_o,
  output logic            chan_end_o
);
  logic [SA_W-1:0]  samp_q;
  logic [PER_W-1:0] per_q;
  logic [CH_W-1:0]  chan_q;
  logic             samp_wrap;

  assign samp_wrap  = (samp_q == SA_W'(N_SAMP - 1));
  assign chan_end_o = samp_wrap && (per_q == PER_W'(N_PER - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
      per_q  <= '0;
      chan_q <= '0;
    end else if (clr_i) begin
      samp_q <= '0;
      per_q  <= '0;
      chan_q <= '0;
    end else begin
      if (step_i) begin
        samp_q <= samp_wrap ? '0 : samp_q + SA_W'(1);
        if (samp_wrap) per_q <= chan_end_o ? '0 : per_q + PER_W'(1);
      end
      if (ch_adv_i) chan_q <= chan_q + CH_W'(1);
    end
  end

  assign samp_o = samp_q;
  assign chan_o = chan_q;
endmodule

// File: rtl/exc_sequencer.sv
module exc_sequencer
  import exc_pkg::*;
#(
  parameter int N_SAMP   = 128,
  parameter int N_PER    = 3,
  parameter int N_CH     = 16,
  parameter int DATA_W   = 32,
  parameter int TICK_W   = 24,
  parameter int SYNC_STG = 2,
  localparam int SA_W    = $clog2(N_SAMP),
  localparam int CH_W    = $clog2(N_CH),
  localparam int NCH_W   = $clog2(N_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              is_master_i,
  input  logic [TICK_W-1:0] interval_i,
  input  logic [NCH_W-1:0]  n_chan_i,
  input  logic              rel_i,
  input  logic [DATA_W-1:0] samp_data_i,
  output logic              rel_pull_o,
  output logic [SA_W-1:0]   samp_addr_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [DATA_W-1:0] mod_o,
  output logic              bus_req_o,
  output logic              hv_en_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o
);
  seq_state_t        state_q, state_d;
  logic [TICK_W-1:0] iv_q;
  logic [CH_W-1:0]   last_ch_q, last_ch_d;
  logic [DATA_W-1:0] mod_q;
  logic              req_q, fail_q;
  logic              rel_s, tick, chan_end, accept, in_run;

  assign accept = (state_q == S_IDLE) && start_i && !abort_i;
  assign in_run = (state_q == S_RUN) && !abort_i;

  exc_rel_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rel_i),
    .q_o   (rel_s)
  );

  exc_interval_timer #(.W(TICK_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (in_run),
    .limit_i(iv_q),
    .tick_o (tick)
  );

  exc_pos_counter #(.N_SAMP(N_SAMP), .N_PER(N_PER), .N_CH(N_CH)) u_pos (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (accept),
    .step_i    (tick),
    .ch_adv_i  ((state_q == S_NEXT) && (chan_o != last_ch_q) && !abort_i),
    .samp_o    (samp_addr_o),
    .chan_o    (chan_o),
    .chan_end_o(chan_end)
  );

  // clamp requested channel count to 1..N_CH
  always_comb begin
    if (n_chan_i == '0)                  last_ch_d = '0;
    else if (n_chan_i > NCH_W'(N_CH))    last_ch_d = CH_W'(N_CH - 1);
    else                                 last_ch_d = CH_W'(n_chan_i - NCH_W'(1));
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start_i) state_d = S_WAIT;
      S_WAIT: if (rel_s) state_d = S_RUN;
      S_RUN:  if (tick && chan_end) state_d = S_NEXT;
      S_NEXT: state_d = (chan_o == last_ch_q) ? S_DONE : S_RUN;
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if (abort_i) state_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      iv_q      <= TICK_W'(1);
      last_ch_q <= '0;
      mod_q     <= '0;
      req_q     <= 1'b0;
      fail_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= tick;
      if (accept) begin
        iv_q      <= (interval_i == '0) ? TICK_W'(1) : interval_i;
        last_ch_q <= last_ch_d;
        fail_q    <= 1'b0;
      end
      if (abort_i) begin
        mod_q  <= '0;
        fail_q <= 1'b1;
      end else if (tick) begin
        mod_q <= samp_data_i;
      end
    end
  end

  assign rel_pull_o = (state_q == S_IDLE) || (state_q == S_DONE);
  assign busy_o     = (state_q == S_WAIT) || (state_q == S_RUN) || (state_q == S_NEXT);
  assign done_o     = (state_q == S_DONE);
  assign hv_en_o    = is_master_i && ((state_q == S_RUN) || (state_q == S_NEXT));
  assign mod_o      = mod_q;
  assign bus_req_o  = req_q;
  assign fail_o     = fail_q;
endmodule

// File: rtl/exc_sequencer_chk.sv
module exc_sequencer_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              abort_i,
  input logic              is_master_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              bus_req_o,
  input logic              hv_en_o,
  input logic              rel_pull_o,
  input logic              fail_o,
  input logic [DATA_W-1:0] mod_o
);
  a_r8_abort_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && mod_o == '0 && fail_o && !bus_req_o));

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_done_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(bus_req_o));

  a_r6_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r2_released_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !rel_pull_o);

  a_r9_hv_master_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_en_o |-> (is_master_i && busy_o));

  a_r3_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (busy_o || done_o || $past(abort_i)));
endmodule

bind exc_sequencer exc_sequencer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .abort_i    (abort_i),
  .is_master_i(is_master_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .bus_req_o  (bus_req_o),
  .hv_en_o    (hv_en_o),
  .rel_pull_o (rel_pull_o),
  .fail_o     (fail_o),
  .mod_o      (mod_o)
);

// File: tb/exc_sequencer_tb.sv
module exc_sequencer_tb;
  localparam int PER_CH = 384;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, abort_i = 1'b0, is_master_i = 1'b0, rel_i = 1'b0;
  logic [23:0] interval_i = 24'd1;
  logic [4:0]  n_chan_i = 5'd1;
  logic [31:0] samp_data_i;
  logic        rel_pull_o, bus_req_o, hv_en_o, busy_o, done_o, fail_o;
  logic [6:0]  samp_addr_o;
  logic [3:0]  chan_o;
  logic [31:0] mod_o;

  int checks = 0;
  int fails  = 0;
  int seed   = 32'h1F3A;

  always #10 clk_i = ~clk_i;

  exc_sequencer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .abort_i(abort_i),
    .is_master_i(is_master_i), .interval_i(interval_i), .n_chan_i(n_chan_i),
    .rel_i(rel_i), .samp_data_i(samp_data_i), .rel_pull_o(rel_pull_o),
    .samp_addr_o(samp_addr_o), .chan_o(chan_o), .mod_o(mod_o),
    .bus_req_o(bus_req_o), .hv_en_o(hv_en_o), .busy_o(busy_o),
    .done_o(done_o), .fail_o(fail_o)
  );

  function automatic logic [31:0] tbl(input int ch, input int a);
    return (32'(ch) << 24) | (32'(a) << 8) | 32'h5A;
  endfunction

  function automatic int eff_chan(input int n);
    if (n == 0) return 1;
    if (n > 16) return 16;
    return n;
  endfunction

  always_comb samp_data_i = tbl(int'(chan_o), int'(samp_addr_o));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic full_run(input int n, input int iv, input bit master, input bit disturb);
    int k = 0, last_cyc = 0, cyc = 0, total, ivf;
    bit prev_req = 0, clr_start = 0, seen_done = 0;
    ivf   = (iv == 0) ? 1 : iv;
    total = eff_chan(n) * PER_CH;
    @(negedge clk_i);
    n_chan_i = 5'(n); interval_i = 24'(iv); is_master_i = master;
    rel_i = 0; start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    chk(busy_o == 1, "R2 busy", busy_o, 1);
    chk(rel_pull_o == 0, "R2 release", rel_pull_o, 0);
    chk(fail_o == 0, "R8 fail cleared", fail_o, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      chk(bus_req_o == 0, "R2 no req before release", bus_req_o, 0);
    end
    rel_i = 1;
    while (!seen_done && cyc < 60000) begin
      @(negedge clk_i);
      cyc++;
      if (clr_start) begin start_i = 0; clr_start = 0; end
      if (done_o) begin
        seen_done = 1;
        chk(k == total, "R5 request count", k, total);
        chk(prev_req == 1, "R6 done after last req", prev_req, 1);
      end
      if (bus_req_o) begin
        chk(mod_o == tbl(k / PER_CH, k % 128), "R4 sample order", mod_o, tbl(k / PER_CH, k % 128));
        if (k > 0) begin
          int eg = (k % PER_CH == 0) ? ivf + 1 : ivf;
          chk(cyc - last_cyc == eg, (k % PER_CH == 0) ? "R3 channel gap" : "R3 interval", cyc - last_cyc, eg);
        end
        chk(hv_en_o == master || k == total - 1, "R9 hv enable", hv_en_o, master);
        last_cyc = cyc;
        k++;
        if (disturb && k == 10) begin
          interval_i = 24'(iv + 4); n_chan_i = 5'd1; start_i = 1; clr_start = 1; // R7
        end
      end
      prev_req = bus_req_o;
    end
    chk(seen_done == 1, "R6 done seen", seen_done, 1);
    @(negedge clk_i);
    chk(busy_o == 0, "R6 idle after done", busy_o, 0);
    chk(rel_pull_o == 1, "R6 line pulled", rel_pull_o, 1);
    chk(done_o == 0, "R6 done single", done_o, 0);
    chk(fail_o == 0, "R8 no fail on clean run", fail_o, 0);
    rel_i = 0;
  endtask

  initial begin
    #3_800_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int k;
    void'($urandom(seed));
    #5;
    chk(busy_o == 0 && done_o == 0 && bus_req_o == 0, "R1 reset flags", busy_o, 0);
    chk(mod_o == 0 && fail_o == 0 && hv_en_o == 0, "R1 reset outputs", mod_o, 0);
    chk(rel_pull_o == 1, "R1 reset line", rel_pull_o, 1);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    full_run(2, 3, 1, 0);
    full_run(0, 0, 0, 0);           // R5 zero channels, R3 zero interval
    full_run(3, 2, 1, 1);           // R7 disturbance
    for (int r = 0; r < 3; r++) full_run(1 + int'($urandom % 3), 1 + int'($urandom % 4), 1'($urandom % 2), 0);
    full_run(20, 1, 1, 0);          // R5 clamp to 16

    // R8 abort mid-run
    @(negedge clk_i);
    n_chan_i = 5'd2; interval_i = 24'd2; is_master_i = 1; start_i = 1; rel_i = 1;
    @(negedge clk_i); start_i = 0;
    k = 0;
    while (k < 5) begin @(negedge clk_i); if (bus_req_o) k++; end
    abort_i = 1;
    @(negedge clk_i); abort_i = 0;
    chk(busy_o == 0, "R8 abort idle", busy_o, 0);
    chk(mod_o == 0, "R8 abort zero output", mod_o, 0);
    chk(fail_o == 1, "R8 abort fail flag", fail_o, 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      chk(bus_req_o == 0, "R8 no req after abort", bus_req_o, 0);
    end
    chk(fail_o == 1, "R8 fail sticky", fail_o, 1);
    rel_i = 0;
    full_run(1, 1, 0, 0);           // fail clears on start

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule